// File: doc/BRIEF.md
# Rectangular Sprite Blit Engine

This engine copies a rectangle of pixels out of a 256 by 256 sprite store into a 128 by 128 framebuffer. It moves one pixel per clock. A CPU sets it up through eight byte-wide registers: the destination corner, the source corner, the width and the height, a fill colour, and a start register. Bit 7 of the width register mirrors the copy left to right. Bit 7 of the height register mirrors it top to bottom. A source pixel of value zero is transparent: the engine writes nothing for it, but still spends that pixel's clock on it.

In fill mode the engine writes every covered pixel with the bitwise inverse of the fill colour register. It ignores the source data in this mode. The width, destination X and source X registers are read again at the end of every row, so a write to them during a blit changes the rows that follow. When a blit finishes, the engine can raise an interrupt. A 2-bit quadrant output holds the top bits of the source coordinates that were read last. The CPU's memory banking uses this output to choose which quarter of sprite memory it can see.

The sprite store has a synchronous read. Its data comes back one clock after the address, so each framebuffer write appears one clock after the matching source read.

Top module: `sprite_blitter`

## Requirements
- R1: The register offsets are 0 destination X, 1 destination Y, 2 source X, 3 source Y, 4 width (bits 6:0, bit 7 mirrors horizontally), 5 height (bits 6:0, bit 7 mirrors vertically), 6 start, 7 fill colour. A write followed by a read of the same offset returns the written byte. Reading offset 6 returns the busy flag in bit 0 and zero in the other bits.
- R2: While `dma_en` is low, register writes (start included) have no effect and `reg_rdata` reads zero.
- R3: A write of a value with bit 0 set to offset 6 starts a blit. `busy` is high from the next cycle for exactly W×H cycles, where W and H are the 7-bit sizes.
- R4: Pixels are visited in row-major order. `src_addr` is {source Y, source X}, 8 bits each. The write for each pixel appears on the cycle after its read, with `dst_addr` = {destination Y, destination X}, 7 bits each and wrapping. A source value of 0 produces no write.
- R5: With horizontal mirroring, each row's source X starts at X+W-1 and counts down. With vertical mirroring, source Y starts at Y+H-1 and counts down. Source coordinates wrap modulo 256.
- R6: With `fill_en` high, every covered pixel is written with the inverse of register 7 (42 gives 213), whatever the source data.
- R7: Width, its mirror bit, destination X and source X are sampled at blit start and again at each row end. A write made during a row applies from the next row.
- R8: Any start write clears `irq`. A start write of 0 starts nothing. When a blit ends, `irq` is set in the cycle where `busy` falls, if `irq_en` is high at that moment.
- R9: A start with zero width or zero height covers no pixel. It leaves `busy` low and sets `irq` in the next cycle if `irq_en` is high.
- R10: `quadrant` is {bit 7 of source Y, bit 7 of source X} for the most recent source read.
- R11: After reset, `busy`, `irq`, `dst_we` and `quadrant` are zero and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_en | input | 1 | Enables register access |
| irq_en | input | 1 | Enables the completion interrupt |
| fill_en | input | 1 | Selects solid fill mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| src_re | output | 1 | Sprite memory read enable |
| src_addr | output | 16 | Sprite memory address {Y, X} |
| src_data | input | 8 | Sprite data, one cycle after the address |
| dst_we | output | 1 | Framebuffer write enable |
| dst_addr | output | 14 | Framebuffer address {Y, X} |
| dst_data | output | 8 | Framebuffer write data |
| busy | output | 1 | A blit is in progress |
| irq | output | 1 | Completion interrupt |
| quadrant | output | 2 | Top bits of the last source coordinates |

## Verification
A wrong column or row counter shows up at once at the framebuffer port. A write lands on the wrong address, or a row runs one pixel too long, within a clock of the fault. A wrong mirror or resampling state shows up at the next row boundary, both in the written addresses and in the quadrant output. The bench predicts the port values for every cycle: busy, write enable, address, data, interrupt and quadrant. A corrupted count therefore fails at the first cycle it reaches the ports, rather than only at the end of the blit.

// File: rtl/sprite_blitter.sv
module sprite_blitter #(
  parameter int FB_W = 7,
  parameter int SP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dma_en,
  input  logic                 irq_en,
  input  logic                 fill_en,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  output logic                 src_re,
  output logic [2*SP_W-1:0]    src_addr,
  input  logic [7:0]           src_data,
  output logic                 dst_we,
  output logic [2*FB_W-1:0]    dst_addr,
  output logic [7:0]           dst_data,
  output logic                 busy,
  output logic                 irq,
  output logic [1:0]           quadrant
);
  localparam logic [2:0] A_VX = 3'd0, A_VY = 3'd1, A_GX = 3'd2, A_GY = 3'd3;
  localparam logic [2:0] A_W = 3'd4, A_H = 3'd5, A_GO = 3'd6, A_COL = 3'd7;
  localparam logic [FB_W-1:0] F1 = 1;
  localparam logic [SP_W-1:0] S1 = 1;

  logic [7:0]      regs [8];
  logic [FB_W-1:0] dx, dy, col, row, wl, hl, pdx, pdy;
  logic [SP_W-1:0] sx, sy;
  logic            hf, vf, pv, q_x, q_y, irq_q;

  wire             wr         = reg_we & dma_en;
  wire             start_fire = wr && (reg_addr == A_GO);
  wire             go         = start_fire && reg_wdata[0];
  wire [FB_W-1:0]  w_live     = regs[A_W][FB_W-1:0];
  wire [FB_W-1:0]  h_live     = regs[A_H][FB_W-1:0];
  wire [FB_W:0]    col_n      = {1'b0, col} + (FB_W+1)'(1);
  wire [FB_W:0]    row_n      = {1'b0, row} + (FB_W+1)'(1);
  wire             row_end    = col_n >= {1'b0, wl};
  wire             last_row   = row_n >= {1'b0, hl};
  wire [SP_W-1:0]  sx_row     = regs[A_W][7] ? regs[A_GX][SP_W-1:0] + SP_W'(w_live) - S1
                                             : regs[A_GX][SP_W-1:0];
  wire [SP_W-1:0]  sy_first   = regs[A_H][7] ? regs[A_GY][SP_W-1:0] + SP_W'(h_live) - S1
                                             : regs[A_GY][SP_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= '0;
      busy <= 1'b0; irq_q <= 1'b0; pv <= 1'b0; q_x <= 1'b0; q_y <= 1'b0;
      dx <= '0; dy <= '0; col <= '0; row <= '0; wl <= '0; hl <= '0;
      pdx <= '0; pdy <= '0; sx <= '0; sy <= '0; hf <= 1'b0; vf <= 1'b0;
    end else begin
      if (wr && reg_addr != A_GO) regs[reg_addr] <= reg_wdata;
      pv  <= busy;
      pdx <= dx;
      pdy <= dy;
      if (busy) begin
        q_x <= sx[SP_W-1];
        q_y <= sy[SP_W-1];
      end
      if (go) begin
        busy  <= (w_live != '0) && (h_live != '0);
        irq_q <= irq_en && ((w_live == '0) || (h_live == '0));
        col <= '0; row <= '0; wl <= w_live; hl <= h_live;
        hf  <= regs[A_W][7]; vf <= regs[A_H][7];
        dx  <= regs[A_VX][FB_W-1:0]; dy <= regs[A_VY][FB_W-1:0];
        sx  <= sx_row; sy <= sy_first;
      end else begin
        if (start_fire) irq_q <= 1'b0;
        if (busy) begin
          if (row_end) begin
            col <= '0; row <= row + F1;
            wl  <= w_live; hf <= regs[A_W][7];
            dx  <= regs[A_VX][FB_W-1:0]; sx <= sx_row;
            dy  <= dy + F1;
            sy  <= vf ? sy - S1 : sy + S1;
            if (last_row) begin
              busy  <= 1'b0;
              irq_q <= irq_en;
            end
          end else begin
            col <= col + F1;
            dx  <= dx + F1;
            sx  <= hf ? sx - S1 : sx + S1;
          end
        end
      end
    end
  end

  assign src_re    = busy;
  assign src_addr  = {sy, sx};
  assign dst_we    = pv && (fill_en || src_data != 8'd0);
  assign dst_addr  = {pdy, pdx};
  assign dst_data  = fill_en ? ~regs[A_COL] : src_data;
  assign reg_rdata = !dma_en ? 8'd0 : (reg_addr == A_GO ? {7'd0, busy} : regs[reg_addr]);
  assign irq       = irq_q;
  assign quadrant  = {q_y, q_x};

  p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !$rose(busy));
  p_idle_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !dst_we);
  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> $past(src_re));
  p_dst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && $past(dst_we) && !$past(go, 2) &&
     dst_addr[2*FB_W-1:FB_W] == $past(dst_addr[2*FB_W-1:FB_W]))
    |-> dst_addr[FB_W-1:0] == $past(dst_addr[FB_W-1:0]) + F1);
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && w_live != '0 && h_live != '0) |=> (!irq && busy));
  p_irq_rise_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy);
endmodule

// File: tb/sprite_blitter_test.sv
`timescale 1ns/1ps
module sprite_blitter_test;
  typedef struct packed {
    bit        busy;
    bit        we;
    bit [13:0] addr;
    bit [7:0]  data;
    bit        irq;
    bit        cq;
    bit [1:0]  q;
  } rec_t;

  logic clk = 0, rst_n = 0, dma_en = 1, irq_en = 0, fill_en = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, src_q = 0;
  logic [7:0] reg_rdata, dst_data;
  logic src_re, dst_we, busy, irq;
  logic [15:0] src_addr;
  logic [13:0] dst_addr;
  logic [1:0] quadrant;

  int nchk = 0, nerr = 0, bcnt = 0;
  bit mon_on = 0, irq_m = 0, finished = 0;
  bit [1:0] q_m = 0;
  string tag = "R4";
  rec_t expq[$];

  always #5 clk = ~clk;

  sprite_blitter uut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .irq_en(irq_en), .fill_en(fill_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_re(src_re), .src_addr(src_addr), .src_data(src_q),
    .dst_we(dst_we), .dst_addr(dst_addr), .dst_data(dst_data),
    .busy(busy), .irq(irq), .quadrant(quadrant)
  );

  function automatic logic [7:0] spr(input logic [15:0] a);
    if (a[2:0] == 3'd0) return 8'd0;
    return (a[7:0] + a[15:8] * 8'd3) | 8'h01;
  endfunction

  always @(posedge clk) src_q <= spr(src_addr);

  always @(negedge clk) if (busy) bcnt++;

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      rec_t e;
      bit bad;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        irq_m = e.irq;
        if (e.cq) q_m = e.q;
      end else begin
        e = '0;
        e.irq = irq_m;
      end
      nchk++;
      bad = (busy !== e.busy) || (dst_we !== e.we) || (irq !== e.irq) || (quadrant !== q_m) ||
            (e.we && (dst_addr !== e.addr || dst_data !== e.data));
      if (bad) begin
        nerr++;
        $display("FAIL %s cycle: busy=%b/%b we=%b/%b addr=%h/%h data=%0d/%0d irq=%b/%b quad=%b/%b (got/expected)",
                 tag, busy, e.busy, dst_we, e.we, dst_addr, e.addr, dst_data, e.data, irq, e.irq, quadrant, q_m);
      end
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic gen(input int vx0, vy, gx0, gy, wb0, hb, vx1, gx1, wb1,
                     input bit fill, input int colr, input bit ien);
    rec_t r, pend;
    int h, w, wb, gx, vx, x, y;
    bit hf, vf;
    logic [7:0] d;
    h = hb & 127;
    vf = ((hb >> 7) & 1) != 0;
    pend = '0;
    if ((wb0 & 127) != 0 && h != 0) begin
      for (int rw = 0; rw < h; rw++) begin
        wb = (rw == 0) ? wb0 : wb1;
        w  = wb & 127;
        hf = ((wb >> 7) & 1) != 0;
        gx = (rw == 0) ? gx0 : gx1;
        vx = (rw == 0) ? vx0 : vx1;
        for (int c = 0; c < w; c++) begin
          r = pend; r.busy = 1; r.irq = 0;
          expq.push_back(r);
          x = (hf ? gx + w - 1 - c : gx + c) & 255;
          y = (vf ? gy + h - 1 - rw : gy + rw) & 255;
          d = spr(16'((y << 8) | x));
          pend.we   = fill || d != 0;
          pend.data = fill ? 8'(~colr) : d;
          pend.addr = 14'((((vy + rw) & 127) << 7) | ((vx + c) & 127));
          pend.cq   = 1;
          pend.q    = 2'(((y >> 7) << 1) | (x >> 7));
        end
      end
    end
    r = pend; r.busy = 0; r.irq = ien;
    expq.push_back(r);
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk) #1;
    reg_we = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(posedge clk) #1;
    reg_we = 0;
  endtask

  task automatic rd(input int a, input int exp, input string t);
    @(posedge clk) #1;
    reg_addr = 3'(a);
    #2 chk(reg_rdata === 8'(exp), t, reg_rdata, exp);
  endtask

  task automatic start(input bit v, input int vx0, vy, gx0, gy, wb0, hb, vx1, gx1, wb1,
                       input int colr);
    @(posedge clk) #1;
    reg_we = 1; reg_addr = 3'd6; reg_wdata = {7'd0, v};
    @(posedge clk);
    bcnt = 0;
    if (dma_en) begin
      if (v) gen(vx0, vy, gx0, gy, wb0, hb, vx1, gx1, wb1, fill_en, colr, irq_en);
      else   gen(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    end
    #1 reg_we = 0;
  endtask

  task automatic wait_done();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic blit(input int vx, vy, gx, gy, wb, hb, colr, input string t);
    tag = t;
    wr(0, vx); wr(1, vy); wr(2, gx); wr(3, gy); wr(4, wb); wr(5, hb); wr(7, colr);
    start(1'b1, vx, vy, gx, gy, wb, hb, vx, gx, wb, colr);
    wait_done();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL R3 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk(busy === 0 && irq === 0 && dst_we === 0, "R11 outputs", {busy, irq, dst_we}, 0);
    chk(quadrant === 0, "R11 quadrant", quadrant, 0);
    for (int a = 0; a < 8; a++) rd(a, 0, "R11 register");
    mon_on = 1;

    // R1: register readback
    wr(0, 8'h15); wr(2, 8'hA3); wr(4, 8'h87); wr(7, 8'h5C);
    rd(0, 8'h15, "R1 dst X"); rd(2, 8'hA3, "R1 src X");
    rd(4, 8'h87, "R1 width"); rd(7, 8'h5C, "R1 colour"); rd(6, 0, "R1 busy idle");

    // R3/R4: plain copy with interrupt
    irq_en = 1;
    tag = "R4";
    wr(0, 10); wr(1, 20); wr(2, 3); wr(3, 5); wr(4, 6); wr(5, 4);
    start(1'b1, 10, 20, 3, 5, 6, 4, 10, 3, 6, 0);
    rd(6, 1, "R1 busy during blit");
    wait_done();
    chk(bcnt == 24, "R3 busy cycles", bcnt, 24);
    chk(irq === 1, "R8 irq at end", irq, 1);

    // R8: start write of 0 clears irq only
    tag = "R8";
    start(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    wait_done();
    chk(irq === 0, "R8 start-0 clears", irq, 0);
    chk(bcnt == 0, "R8 start-0 no blit", bcnt, 0);

    // R5/R10: both mirrors, source crosses X 128 and wraps Y
    blit(100, 120, 120, 250, 8'h80 | 12, 8'h80 | 9, 0, "R5");
    chk(bcnt == 108, "R5 busy cycles", bcnt, 108);
    chk(quadrant === q_m, "R10 quadrant after mirror", quadrant, q_m);

    // R10: high quadrant
    blit(0, 0, 200, 130, 3, 2, 0, "R10");
    chk(quadrant === 2'b11, "R10 quadrant high", quadrant, 3);
    blit(0, 0, 5, 6, 1, 1, 0, "R10");
    chk(quadrant === 2'b00, "R10 quadrant low", quadrant, 0);

    // R6: fill mode, colour 42 writes 213
    fill_en = 1;
    blit(60, 70, 0, 0, 5, 3, 42, "R6");
    fill_en = 0;
    chk(bcnt == 15, "R6 busy cycles", bcnt, 15);

    // R7: width, mirror and dst X changed during row 0
    tag = "R7";
    wr(0, 30); wr(1, 40); wr(2, 16); wr(3, 9); wr(4, 6); wr(5, 4);
    start(1'b1, 30, 40, 16, 9, 6, 4, 50, 16, 8'h83, 0);
    wr(4, 8'h83);
    wr(0, 50);
    wait_done();
    chk(bcnt == 15, "R7 busy cycles", bcnt, 15);

    // R9: zero width and zero height
    tag = "R9";
    wr(4, 0); wr(5, 5);
    start(1'b1, 0, 0, 0, 0, 0, 5, 0, 0, 0, 0);
    wait_done();
    chk(irq === 1 && bcnt == 0, "R9 zero width irq", {irq, 8'(bcnt)}, 256);
    irq_en = 0;
    wr(4, 5); wr(5, 0);
    start(1'b1, 0, 0, 0, 0, 5, 0, 0, 0, 5, 0);
    wait_done();
    chk(irq === 0 && bcnt == 0, "R9 zero height no irq", {irq, 8'(bcnt)}, 0);

    // R8: interrupt disabled
    blit(5, 5, 7, 7, 3, 3, 0, "R8");
    chk(irq === 0, "R8 irq disabled", irq, 0);

    // R2: access gated off
    wr(0, 8'h11);
    dma_en = 0;
    wr(0, 8'h66);
    rd(0, 0, "R2 read gated");
    tag = "R2";
    start(1'b1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk(bcnt == 0, "R2 start ignored", bcnt, 0);
    dma_en = 1;
    rd(0, 8'h11, "R2 write ignored");

    // R3: maximum width, destination wraps
    irq_en = 1;
    blit(100, 126, 40, 60, 127, 2, 0, "R3");
    chk(bcnt == 254, "R3 max width cycles", bcnt, 254);
    chk(irq === 1, "R8 irq after max blit", irq, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule